// File: doc/BRIEF.md
# EEPROM Word Read Register

This block is a single 32-bit control and status register in a memory-mapped register space. Software reads one 16-bit word from a configuration EEPROM by writing a start bit together with a word address. The block then issues a one-cycle request on a word-wide EEPROM read port and waits for the port's valid strobe. When the word arrives, the block raises a done flag and places the word in the upper half of the register.

Two register layouts exist, selected by a strap input that says whether an EEPROM is fitted. The layouts put the address field and the done flag at different bit positions. Only the fitted layout reports completion on bit 4. Software can therefore detect an EEPROM by writing 0x1 and polling bit 4 for a bounded time.

Writes are synchronous. Reads are combinational and return zero at any offset other than the register's own.

Top module: `eeprom_word_reg`

## Requirements
- R1: After reset the register reads 0x00000000, the read request is low and the request address is 0.
- R2: A write at offset 0x0014 with bit 0 set, while no read is in progress, raises the request for exactly one cycle after the write edge. In the fitted layout (strap high) the request address is write bits 15:8.
- R3: In the unfitted layout (strap low), the request address is write bits 9:2.
- R4: A read of the register returns the done flag on bit 4 in the fitted layout and on bit 1 in the unfitted layout. Every other bit below 16 reads 0.
- R5: Bits 31:16 take the port data on the clock edge where the valid strobe is sampled during a read, and the done flag sets on that same edge. Before that edge, bits 31:16 keep their previous value.
- R6: The done flag clears on the edge that accepts a new start. It stays set until such a start.
- R7: A start written while a read is in progress is ignored: no new request, the request address does not change, and the pending read completes with its original address.
- R8: A write with bit 0 clear, or a write to any other offset, starts nothing. A read at any other offset returns 0.
- R9: After 0x1 is written with the strap high, bit 4 reads 1 once the port has answered. With the strap low, bit 4 stays 0.
- R10: A valid strobe while no read is in progress changes neither the data field nor the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ee_fitted_i | input | 1 | Layout strap: 1 = EEPROM fitted layout, 0 = alternate layout |
| reg_addr_i | input | 16 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| ee_req_o | output | 1 | One-cycle read request to the EEPROM port |
| ee_addr_o | output | 8 | Word address held for the request |
| ee_rdata_i | input | 16 | Word returned by the port |
| ee_valid_i | input | 1 | Port data valid |

## Verification
The request is due in the cycle right after the write edge that carries the start bit. Data and done are due right after the edge on which the valid strobe is sampled. A cleared done is due right after the accepting write edge. Register reads are due in the same cycle as the offset, because the read path has no register. The bench updates a behavioural model on each rising edge using the inputs held since the previous falling edge. It compares the model with the outputs one time unit after that edge, so every result is checked in the cycle it is due. Directed checks, such as done holding and stray strobes being ignored, sample after the driven inputs have settled and before the next stimulus.

// File: rtl/eeprom_reg_pkg.sv
package eeprom_reg_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned START_BIT    = 0;
  localparam int unsigned DONE_FITTED  = 4;
  localparam int unsigned DONE_ALT     = 1;
  localparam int unsigned ALSB_FITTED  = 8;
  localparam int unsigned ALSB_ALT     = 2;
  localparam int unsigned DATA_LSB     = 16;

  typedef enum logic {
    LAYOUT_ALT    = 1'b0,
    LAYOUT_FITTED = 1'b1
  } layout_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rd_state_e;
endpackage

// File: rtl/eeprom_reg_dec.sv
module eeprom_reg_dec #(
  parameter int unsigned AW     = 16,
  parameter logic [AW-1:0] OFFSET = 16'h0014
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          start_bit_i,
  input  logic [31:0]   word_i,
  output logic          start_o,
  output logic [31:0]   rdata_o
);
  logic hit;

  assign hit     = (addr_i == OFFSET);
  assign start_o = hit && wr_i && start_bit_i;
  assign rdata_o = hit ? word_i : '0;
endmodule

// File: rtl/eeprom_fmt.sv
module eeprom_fmt
  import eeprom_reg_pkg::*;
#(
  parameter int unsigned EE_AW = 8,
  parameter int unsigned EE_DW = 16
) (
  input  layout_e             layout_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic                done_i,
  input  logic [EE_DW-1:0]    data_i,
  output logic [EE_AW-1:0]    addr_o,
  output logic [REG_W-1:0]    word_o
);
  localparam int unsigned DONE_POS_F = DONE_FITTED;
  localparam int unsigned DONE_POS_A = DONE_ALT;

  always_comb begin
    if (layout_i == LAYOUT_FITTED) addr_o = wdata_i[ALSB_FITTED +: EE_AW];
    else                           addr_o = wdata_i[ALSB_ALT +: EE_AW];
  end

  always_comb begin
    word_o = '0;
    word_o[DATA_LSB +: EE_DW] = data_i;
    if (layout_i == LAYOUT_FITTED) word_o[DONE_POS_F] = done_i;
    else                           word_o[DONE_POS_A] = done_i;
  end
endmodule

// File: rtl/eeprom_rd_ctl.sv
module eeprom_rd_ctl
  import eeprom_reg_pkg::*;
#(
  parameter int unsigned EE_AW = 8,
  parameter int unsigned EE_DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [EE_AW-1:0] addr_i,
  input  logic             ee_valid_i,
  input  logic [EE_DW-1:0] ee_rdata_i,
  output logic             ee_req_o,
  output logic [EE_AW-1:0] ee_addr_o,
  output logic             done_o,
  output logic [EE_DW-1:0] data_o
);
  rd_state_e  state_q;
  logic       accept;
  logic       capture;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign capture = (state_q == ST_WAIT) && ee_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ee_req_o  <= 1'b0;
      ee_addr_o <= '0;
      done_o    <= 1'b0;
      data_o    <= '0;
    end else begin
      ee_req_o <= accept;
      if (accept) begin
        state_q   <= ST_WAIT;
        ee_addr_o <= addr_i;
        done_o    <= 1'b0;
      end else if (capture) begin
        state_q <= ST_IDLE;
        data_o  <= ee_rdata_i;
        done_o  <= 1'b1;
      end
    end
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_req_o |=> !ee_req_o);
  // R7
  busy_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !ee_valid_i) |=> $stable(ee_addr_o) && !ee_req_o);
  // R6
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !done_o && ee_req_o);
  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture |=> $stable(data_o));
  // R5
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> done_o && (data_o == $past(ee_rdata_i)));
  // R10
  idle_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> $stable(done_o));
endmodule

// File: rtl/eeprom_word_reg.sv
module eeprom_word_reg
  import eeprom_reg_pkg::*;
#(
  parameter int unsigned   AW     = 16,
  parameter logic [AW-1:0] OFFSET = 16'h0014,
  parameter int unsigned   EE_AW  = 8,
  parameter int unsigned   EE_DW  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ee_fitted_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_wr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             ee_req_o,
  output logic [EE_AW-1:0] ee_addr_o,
  input  logic [EE_DW-1:0] ee_rdata_i,
  input  logic             ee_valid_i
);
  layout_e          layout;
  logic             start;
  logic [EE_AW-1:0] wr_addr;
  logic             done;
  logic [EE_DW-1:0] data;
  logic [31:0]      word;

  assign layout = ee_fitted_i ? LAYOUT_FITTED : LAYOUT_ALT;

  eeprom_reg_dec #(.AW(AW), .OFFSET(OFFSET)) u_dec (
    .addr_i      (reg_addr_i),
    .wr_i        (reg_wr_i),
    .start_bit_i (reg_wdata_i[START_BIT]),
    .word_i      (word),
    .start_o     (start),
    .rdata_o     (reg_rdata_o)
  );

  eeprom_fmt #(.EE_AW(EE_AW), .EE_DW(EE_DW)) u_fmt (
    .layout_i (layout),
    .wdata_i  (reg_wdata_i),
    .done_i   (done),
    .data_i   (data),
    .addr_o   (wr_addr),
    .word_o   (word)
  );

  eeprom_rd_ctl #(.EE_AW(EE_AW), .EE_DW(EE_DW)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .addr_i     (wr_addr),
    .ee_valid_i (ee_valid_i),
    .ee_rdata_i (ee_rdata_i),
    .ee_req_o   (ee_req_o),
    .ee_addr_o  (ee_addr_o),
    .done_o     (done),
    .data_o     (data)
  );

  // R8
  no_stray_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == OFFSET && reg_wdata_i[START_BIT]) |=> !ee_req_o);
  // R4
  low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(reg_rdata_o[15:0]) <= 1);
endmodule

// File: tb/eeprom_word_reg_tb_top.sv
module eeprom_word_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam logic [15:0] OFF = 16'h0014;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        fitted = 1;
  logic [15:0] reg_addr = OFF;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        ee_req;
  logic [7:0]  ee_addr;
  logic [15:0] ee_rdata = 0;
  logic        ee_valid = 0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_word_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ee_fitted_i(fitted),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .ee_req_o(ee_req), .ee_addr_o(ee_addr),
    .ee_rdata_i(ee_rdata), .ee_valid_i(ee_valid)
  );

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  // reference model state
  bit          m_busy = 0, m_done = 0, m_req = 0;
  logic [7:0]  m_addr = 0;
  logic [15:0] m_data = 0;
  int          pend = 0;
  logic [7:0]  pend_addr = 0;
  bit          inject = 0;

  function automatic logic [31:0] exp_rdata();
    logic [31:0] w;
    w = '0;
    if (reg_addr != OFF) return w;
    w[31:16] = m_data;
    if (fitted) w[4] = m_done; else w[1] = m_done;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model update and per-cycle comparison
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_req = 0; m_addr = 0; m_data = 0; pend = 0;
    end else begin
      if (reg_wr && reg_addr == OFF && reg_wdata[0] && !m_busy) begin
        m_busy = 1; m_done = 0; m_req = 1;
        m_addr = fitted ? reg_wdata[15:8] : reg_wdata[9:2];
      end else begin
        m_req = 0;
        if (m_busy && ee_valid) begin
          m_busy = 0; m_done = 1; m_data = ee_rdata;
        end
      end
      check("R4 R5 R8 register read", reg_rdata, exp_rdata());
      check("R2 R7 request", {31'b0, ee_req}, {31'b0, m_req});
      check("R2 R3 R7 address", {24'b0, ee_addr}, {24'b0, m_addr});
      if (ee_req) begin pend = LAT; pend_addr = ee_addr; end
    end
  end

  // EEPROM port model: fixed latency
  always @(negedge clk) begin
    ee_valid <= 0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin ee_valid <= 1; ee_rdata <= mem_word(pend_addr); end
    end else if (inject) begin
      ee_valid <= 1; ee_rdata <= 16'hDEAD;
    end
  end

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; reg_addr = OFF;
    #1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 reset rdata", reg_rdata, 32'h0);
    check("R1 reset req", {31'b0, ee_req}, 32'h0);
    rst_n = 1;
    wait_cyc(2);

    // R9 presence detect in fitted layout: write 0x1
    reg_write(OFF, 32'h1);
    check("R6 done cleared after start", {31'b0, reg_rdata[4]}, 32'h0);
    wait_cyc(LAT + 4);
    check("R9 fitted bit4", {31'b0, reg_rdata[4]}, 32'h1);
    check("R5 word 0 data", {16'b0, reg_rdata[31:16]}, {16'b0, mem_word(8'd0)});

    // R2 fitted address field
    reg_write(OFF, 32'h0000_2A01);
    wait_cyc(LAT + 4);
    check("R2 word 0x2A data", {16'b0, reg_rdata[31:16]}, {16'b0, mem_word(8'h2A)});
    // R6 done holds
    wait_cyc(10);
    check("R6 done holds", {31'b0, reg_rdata[4]}, 32'h1);

    // R7 start while busy ignored
    reg_write(OFF, 32'h0000_0301);
    reg_write(OFF, 32'h0000_0701);
    wait_cyc(LAT + 4);
    check("R7 busy start ignored", {16'b0, reg_rdata[31:16]}, {16'b0, mem_word(8'h03)});

    // R8 other offset and bit0 clear start nothing
    snap = reg_rdata;
    reg_write(16'h0018, 32'h0000_0901);
    reg_write(OFF, 32'h0000_0900);
    wait_cyc(LAT + 4);
    check("R8 no effect", reg_rdata, snap);
    @(negedge clk); reg_addr = 16'h0018; #1;
    check("R8 other offset reads zero", reg_rdata, 32'h0);
    @(negedge clk); reg_addr = OFF; #1;

    // R10 stray valid while idle
    inject = 1;
    wait_cyc(3);
    inject = 0;
    wait_cyc(1);
    check("R10 stray valid ignored", reg_rdata, snap);

    // R3 alternate layout: address bits 9:2, done on bit 1
    fitted = 0;
    #1;
    check("R4 alt layout done on bit1", reg_rdata, {snap[31:16], 16'h0002});
    reg_write(OFF, {22'b0, 8'h55, 2'b01});
    check("R6 alt done cleared", {31'b0, reg_rdata[1]}, 32'h0);
    wait_cyc(LAT + 4);
    check("R3 alt word 0x55 data", {16'b0, reg_rdata[31:16]}, {16'b0, mem_word(8'h55)});
    check("R4 alt status bits", {16'b0, reg_rdata[15:0]}, 32'h0000_0002);

    // R9 presence detect in alternate layout
    reg_write(OFF, 32'h1);
    wait_cyc(LAT + 4);
    check("R9 alt bit4 stays zero", {31'b0, reg_rdata[4]}, 32'h0);
    check("R9 alt bit1 done", {31'b0, reg_rdata[1]}, 32'h1);

    fitted = 1;
    wait_cyc(2);
    finish_run();
  end
endmodule